// File: doc/BRIEF.md
# Display Command/Parameter Serial Receiver

This block takes the four-wire serial link that a host uses to program a display controller and turns it into bytes in the system clock domain. The four wires are an active-low chip select, a serial clock, serial data and a data/command select. The bits are assembled MSB first. Each finished byte comes out as a one-cycle strobe, with a flag that says whether it is a command or a parameter.

Bytes are also grouped into transactions. A transaction is a command byte plus the parameter bytes that follow it. The transaction closes when the next command byte arrives. At that point a one-cycle completion strobe presents a record for the closed transaction: its opcode, how many parameters it stored, whether the opcode belongs to the supported set, and whether parameters were dropped because the store was full.

The stored parameters of the closed transaction can be read by index while the next transaction is being received. The serial inputs are synchronized into the system clock, so that clock must run at least four times faster than the serial clock.

Top module: `dcx_serial_rx`

## Requirements
- R1: While chip select is high, serial clock edges have no effect: a partly received byte is discarded with its bit count, and no byte is reported for it.
- R2: Data is sampled on the rising serial clock edge and committed on the following falling edge. Bits are assembled MSB first, and every 8 committed bits give one `byte_valid` pulse carrying that byte.
- R3: The data/command line is taken when a byte completes. A 0 marks a command byte (`byte_is_param`=0) and a 1 marks a parameter byte (`byte_is_param`=1).
- R4: A command byte closes the open transaction with a `txn_done` pulse carrying that transaction's opcode and parameter count, then opens a new transaction with no parameters. The first command after reset produces no `txn_done`.
- R5: A command followed directly by another command is reported with `txn_count`=0.
- R6: At most PARAM_DEPTH parameters are stored per command. Further parameters are dropped, `txn_count` saturates at PARAM_DEPTH and `txn_trunc`=1. Otherwise `txn_trunc`=0.
- R7: `txn_known`=1 exactly for opcodes 0x00, 0x01, 0x10, 0x11, 0x28, 0x29, 0x2A, 0x2B, 0x2C, 0x36 and 0x3A.
- R8: `rd_data` returns parameter number `rd_idx` (0 = first) of the last closed transaction. It stays unchanged, even while new parameters arrive, until the next command byte.
- R9: Raising chip select does not close a transaction. Parameters received after reselection keep counting under the same command.
- R10: Parameter bytes that arrive before the first command after reset are reported as bytes but are not counted in any transaction.
- R11: Synchronous active-low reset clears the byte assembler, the open command, the parameter count, the truncation flag and both strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_cs_n | input | 1 | Serial chip select, active low |
| ser_clk | input | 1 | Serial clock |
| ser_dat | input | 1 | Serial data |
| ser_dc | input | 1 | Data/command select: 0 command, 1 parameter |
| rd_idx | input | $clog2(PARAM_DEPTH) | Parameter index for read-back |
| byte_valid | output | 1 | One-cycle strobe for a received byte |
| byte_data | output | 8 | Received byte |
| byte_is_param | output | 1 | 1 for a parameter byte, 0 for a command byte |
| txn_done | output | 1 | One-cycle strobe when a transaction closes |
| txn_cmd | output | 8 | Opcode of the closed transaction |
| txn_count | output | $clog2(PARAM_DEPTH+1) | Stored parameter count |
| txn_known | output | 1 | Opcode is in the supported set |
| txn_trunc | output | 1 | Parameters were dropped |
| rd_data | output | 8 | Parameter at `rd_idx` of the closed transaction |

## Verification
The bench builds the receiver with PARAM_DEPTH=4. With that depth, saturation and truncation are reached after only five parameters, so every count from zero past the cap can be swept, along with each read index and the stored values. The opcode classifier is checked for all 256 codes, and each code's byte value is checked on the byte output. A separate pass carries all 256 values as parameter bytes. Further cases cover chip select raised in the middle of a byte, serial clocking while deselected, parameters before any command, reselection inside a transaction, and a reset in the middle of a transaction.

// File: rtl/dcx_rx_pkg.sv
// Package: shared constants and the opcode classifier for the receiver.
// Assumes 8-bit opcodes; the supported set is fixed at design time.
package dcx_rx_pkg;

    localparam int BYTE_W = 8;

    // Returns 1 when the opcode belongs to the supported command set.
    function automatic logic opcode_known(input logic [BYTE_W-1:0] op);
        case (op)
            8'h00, 8'h01, 8'h10, 8'h11, 8'h28, 8'h29,
            8'h2A, 8'h2B, 8'h2C, 8'h36, 8'h3A: opcode_known = 1'b1;
            default:                           opcode_known = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dcx_sync.sv
// Module: per-bit two-flop synchronizer bank.
// Assumes each input is a level that stays stable for several system clocks.
module dcx_sync #(
    parameter int              W       = 4,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            logic meta_q;
            logic stab_q;
            // Two-stage capture of one asynchronous bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= RST_VAL[g];
                    stab_q <= RST_VAL[g];
                end else begin
                    meta_q <= async_i[g];
                    stab_q <= meta_q;
                end
            end
            assign sync_o[g] = stab_q;
        end
    endgenerate

endmodule

// File: rtl/dcx_byte_asm.sv
// Module: serial byte assembler working on synchronized serial lines.
// Samples data on a serial clock rise and commits it on the following fall,
// MSB first. Chip select high clears the partial byte. Assumes the system
// clock runs at least 4x the serial clock.
module dcx_byte_asm
    import dcx_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              dat_s,
    input  logic              dc_s,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_is_param
);

    localparam int CNT_W = $clog2(BYTE_W);

    logic              sclk_q;
    logic              bit_hold;
    logic              bit_pend;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              rise;
    logic              fall;

    // Serial clock edge detection in the system domain.
    assign rise = sclk_s & ~sclk_q;
    assign fall = ~sclk_s & sclk_q;

    // Bit sampling, commit, byte completion and deselect clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q        <= 1'b0;
            bit_hold      <= 1'b0;
            bit_pend      <= 1'b0;
            shreg         <= '0;
            bit_cnt       <= '0;
            byte_valid    <= 1'b0;
            byte_data     <= '0;
            byte_is_param <= 1'b0;
        end else begin
            sclk_q     <= sclk_s;
            byte_valid <= 1'b0;
            if (cs_n_s) begin
                bit_cnt  <= '0;
                bit_pend <= 1'b0;
            end else if (rise) begin
                bit_hold <= dat_s;
                bit_pend <= 1'b1;
            end else if (fall && bit_pend) begin
                bit_pend <= 1'b0;
                shreg    <= {shreg[BYTE_W-2:0], bit_hold};
                if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                    byte_valid    <= 1'b1;
                    byte_data     <= {shreg[BYTE_W-2:0], bit_hold};
                    byte_is_param <= dc_s;
                    bit_cnt       <= '0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // R1
    deselect_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (bit_cnt == '0 && !bit_pend && !byte_valid));

    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

endmodule

// File: rtl/dcx_txn_track.sv
// Module: groups bytes into command transactions and reports closed ones.
// Assumes bytes arrive as single-cycle strobes. Parameters before the
// first command are ignored. Counts saturate at DEPTH.
module dcx_txn_track
    import dcx_rx_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              byte_is_param,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              swap,
    output logic              txn_done,
    output logic [BYTE_W-1:0] txn_cmd,
    output logic [CNT_W-1:0]  txn_count,
    output logic              txn_known,
    output logic              txn_trunc
);

    logic              open_q;
    logic [BYTE_W-1:0] cur_cmd;
    logic [CNT_W-1:0]  cur_cnt;
    logic              cur_trunc;
    logic              room;

    // Store-path decode for an arriving parameter and bank swap on command.
    assign room    = (cur_cnt < CNT_W'(DEPTH));
    assign wr_en   = byte_valid && byte_is_param && open_q && room;
    assign wr_idx  = cur_cnt[IDX_W-1:0];
    assign wr_data = byte_data;
    assign swap    = byte_valid && !byte_is_param;

    // Transaction state and completion record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q    <= 1'b0;
            cur_cmd   <= '0;
            cur_cnt   <= '0;
            cur_trunc <= 1'b0;
            txn_done  <= 1'b0;
            txn_cmd   <= '0;
            txn_count <= '0;
            txn_known <= 1'b0;
            txn_trunc <= 1'b0;
        end else begin
            txn_done <= 1'b0;
            if (swap) begin
                if (open_q) begin
                    txn_done  <= 1'b1;
                    txn_cmd   <= cur_cmd;
                    txn_count <= cur_cnt;
                    txn_known <= opcode_known(cur_cmd);
                    txn_trunc <= cur_trunc;
                end
                open_q    <= 1'b1;
                cur_cmd   <= byte_data;
                cur_cnt   <= '0;
                cur_trunc <= 1'b0;
            end else if (byte_valid && open_q) begin
                if (room) cur_cnt   <= cur_cnt + 1'b1;
                else      cur_trunc <= 1'b1;
            end
        end
    end

    // R4
    done_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_done |-> $past(byte_valid && !byte_is_param));

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_done |-> (txn_count <= CNT_W'(DEPTH)));

    // R6
    trunc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_done && txn_trunc) |-> (txn_count == CNT_W'(DEPTH)));

    // R10
    no_open_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_q && byte_valid && byte_is_param) |=> (cur_cnt == '0));

endmodule

// File: rtl/dcx_param_buf.sv
// Module: two-bank parameter store. One bank fills while the other holds the
// last closed transaction for read-back; the banks trade roles on swap.
// Assumes wr_idx < DEPTH whenever wr_en is high.
module dcx_param_buf
    import dcx_rx_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              swap,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_data
);

    logic [BYTE_W-1:0] mem [2][DEPTH];
    logic              wr_bank;

    // Bank selection: flips on every command byte.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_bank <= 1'b0;
        else if (swap) wr_bank <= ~wr_bank;
    end

    // Parameter write into the filling bank.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_bank][wr_idx] <= wr_data;
    end

    assign rd_data = mem[~wr_bank][rd_idx];

    // R8
    readback_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !swap |=> ($stable(rd_idx) -> $stable(rd_data)));

endmodule

// File: rtl/dcx_serial_rx.sv
// Module: top of the display command/parameter serial receiver.
// Synchronizes the serial lines, assembles bytes, groups them into command
// transactions and keeps the closed transaction's parameters readable.
// Assumes clk runs at least 4x the serial clock.
module dcx_serial_rx
    import dcx_rx_pkg::*;
#(
    parameter int PARAM_DEPTH = 128,
    localparam int IDX_W = $clog2(PARAM_DEPTH),
    localparam int CNT_W = $clog2(PARAM_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_cs_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_dc,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_is_param,
    output logic              txn_done,
    output logic [BYTE_W-1:0] txn_cmd,
    output logic [CNT_W-1:0]  txn_count,
    output logic              txn_known,
    output logic              txn_trunc,
    output logic [BYTE_W-1:0] rd_data
);

    logic [3:0]        sync_q;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic              swap;

    // Bit order: {dc, data, cs_n, sclk}; cs_n idles high.
    dcx_sync #(.W(4), .RST_VAL(4'b0010)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_dc, ser_dat, ser_cs_n, ser_clk}),
        .sync_o  (sync_q)
    );

    dcx_byte_asm asm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .sclk_s        (sync_q[0]),
        .cs_n_s        (sync_q[1]),
        .dat_s         (sync_q[2]),
        .dc_s          (sync_q[3]),
        .byte_valid    (byte_valid),
        .byte_data     (byte_data),
        .byte_is_param (byte_is_param)
    );

    dcx_txn_track #(.DEPTH(PARAM_DEPTH)) trk_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .byte_valid    (byte_valid),
        .byte_data     (byte_data),
        .byte_is_param (byte_is_param),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_data       (wr_data),
        .swap          (swap),
        .txn_done      (txn_done),
        .txn_cmd       (txn_cmd),
        .txn_count     (txn_count),
        .txn_known     (txn_known),
        .txn_trunc     (txn_trunc)
    );

    dcx_param_buf #(.DEPTH(PARAM_DEPTH)) buf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .swap    (swap),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!byte_valid && !txn_done && txn_count == '0 && !txn_trunc));

endmodule

// File: tb/dcx_serial_rx_tb.sv
module dcx_serial_rx_tb_top;

    localparam int DEPTH = 4;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int HALF  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_cs_n = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic ser_dc = 1'b0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic byte_valid, byte_is_param, txn_done, txn_known, txn_trunc;
    logic [7:0] byte_data, txn_cmd, rd_data;
    logic [CNT_W-1:0] txn_count;

    int checks = 0;
    int errors = 0;
    int n_bytes = 0;
    int n_txn = 0;
    logic [7:0] last_byte = '0;
    logic last_param = 1'b0;
    logic [7:0] t_cmd = '0;
    int t_cnt = 0;
    logic t_known = 1'b0;
    logic t_trunc = 1'b0;

    always #2 clk = ~clk;

    dcx_serial_rx #(.PARAM_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .ser_dc(ser_dc), .rd_idx(rd_idx),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_is_param(byte_is_param), .txn_done(txn_done),
        .txn_cmd(txn_cmd), .txn_count(txn_count), .txn_known(txn_known),
        .txn_trunc(txn_trunc), .rd_data(rd_data)
    );

    // Output monitor, sampling away from the active edge.
    always @(negedge clk) begin
        if (rst_n && byte_valid) begin
            n_bytes    <= n_bytes + 1;
            last_byte  <= byte_data;
            last_param <= byte_is_param;
        end
        if (rst_n && txn_done) begin
            n_txn   <= n_txn + 1;
            t_cmd   <= txn_cmd;
            t_cnt   <= int'(txn_count);
            t_known <= txn_known;
            t_trunc <= txn_trunc;
        end
    end

    function automatic logic exp_known(input int op);
        return op == 'h00 || op == 'h01 || op == 'h10 || op == 'h11 ||
               op == 'h28 || op == 'h29 || op == 'h2A || op == 'h2B ||
               op == 'h2C || op == 'h36 || op == 'h3A;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits, input logic dc);
        ser_cs_n = 1'b0;
        ser_dc   = dc;
        for (int i = 7; i > 7 - nbits; i--) begin
            ser_dat = b[i];
            ticks(HALF);
            ser_clk = 1'b1;
            ticks(HALF);
            ser_clk = 1'b0;
        end
        ticks(8);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic dc);
        send_bits(b, 8, dc);
    endtask

    task automatic close_and_check(input string req, input int cmd, input int cnt,
                                   input int trunc, input int prev_txn);
        send_byte(8'h00, 1'b0);
        check(req, n_txn, prev_txn + 1);
        check(req, int'(t_cmd), cmd);
        check(req, t_cnt, cnt);
        check(req, int'(t_trunc), trunc);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int nb;
        int nt;
        ticks(5);
        // R11 reset state
        check("R11 byte_valid", int'(byte_valid), 0);
        check("R11 txn_done", int'(txn_done), 0);
        check("R11 txn_count", int'(txn_count), 0);
        check("R11 txn_trunc", int'(txn_trunc), 0);
        rst_n = 1'b1;
        ticks(3);

        // R10 parameter before any command is reported but not counted
        send_byte(8'h77, 1'b1);
        check("R10 byte seen", n_bytes, 1);
        check("R3 param flag", int'(last_param), 1);
        // R4 first command after reset does not complete anything
        send_byte(8'h2B, 1'b0);
        check("R4 no txn on first cmd", n_txn, 0);
        check("R3 cmd flag", int'(last_param), 0);
        close_and_check("R10 count", 'h2B, 0, 0, 0);

        // R1 partial byte cut by chip select, then clocking while deselected
        nb = n_bytes;
        send_bits(8'hFF, 5, 1'b1);
        ser_cs_n = 1'b1;
        ticks(6);
        for (int i = 0; i < 16; i++) begin
            ser_clk = 1'b1; ticks(HALF); ser_clk = 1'b0; ticks(HALF);
        end
        check("R1 no byte while deselected", n_bytes, nb);
        send_byte(8'hA5, 1'b1);
        check("R1 clean byte after reselect", n_bytes, nb + 1);
        check("R1 byte value", int'(last_byte), 'hA5);

        // R9 deselect inside a transaction keeps it open
        nt = n_txn;
        send_byte(8'h36, 1'b0);
        send_byte(8'h11, 1'b1);
        ser_cs_n = 1'b1;
        ticks(20);
        check("R9 no close on deselect", n_txn, nt + 1);
        send_byte(8'h22, 1'b1);
        close_and_check("R9 count continues", 'h36, 2, 0, nt + 1);

        // R5 R6 R8 parameter count sweep across the cap
        for (int n = 0; n <= DEPTH + 2; n++) begin
            int stored;
            stored = (n < DEPTH) ? n : DEPTH;
            nt = n_txn;
            send_byte(8'h2A, 1'b0);
            for (int i = 0; i < n; i++) send_byte(8'((n << 4) + i), 1'b1);
            close_and_check(n == 0 ? "R5 zero params" : "R6 count and trunc",
                            'h2A, stored, (n > DEPTH) ? 1 : 0, nt + 1);
            for (int i = 0; i < stored; i++) begin
                rd_idx = IDX_W'(i);
                ticks(1);
                check("R8 readback", int'(rd_data), (n << 4) + i);
            end
            // R8 closed bank unaffected while the new transaction fills
            send_byte(8'hEE, 1'b1);
            send_byte(8'hDD, 1'b1);
            for (int i = 0; i < stored; i++) begin
                rd_idx = IDX_W'(i);
                ticks(1);
                check("R8 stable during fill", int'(rd_data), (n << 4) + i);
            end
        end

        // R2 R3 all byte values as parameters
        send_byte(8'h3A, 1'b0);
        for (int v = 0; v < 256; v++) begin
            send_byte(8'(v), 1'b1);
            check("R2 param byte", int'(last_byte), v);
            check("R3 param flag", int'(last_param), 1);
        end
        close_and_check("R6 long run", 'h3A, DEPTH, 1, n_txn);

        // R7 R4 R2 all opcodes
        for (int op = 0; op < 256; op++) begin
            nt = n_txn;
            send_byte(8'(op), 1'b0);
            check("R2 cmd byte", int'(last_byte), op);
            check("R4 one txn per cmd", n_txn, nt + 1);
            if (op > 0) begin
                check("R7 opcode", int'(t_cmd), op - 1);
                check("R7 known", int'(t_known), int'(exp_known(op - 1)));
            end
        end
        send_byte(8'h00, 1'b0);
        check("R7 last opcode", int'(t_cmd), 255);
        check("R7 last known", int'(t_known), 0);

        // R11 reset in the middle of a transaction clears the open command
        send_byte(8'h29, 1'b0);
        send_byte(8'h01, 1'b1);
        ticks(2);
        rst_n = 1'b0;
        ticks(3);
        rst_n = 1'b1;
        ticks(3);
        nt = n_txn;
        send_byte(8'h28, 1'b0);
        check("R11 open cleared", n_txn, nt);
        close_and_check("R11 fresh txn", 'h28, 0, 0, nt);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule